// File: doc/BRIEF.md
# NaN Format Converter

This block takes a floating-point operand that is already known to be a NaN and re-encodes it in another binary width: 16-bit half, 32-bit single or 64-bit double. The operand is first split into a sign and a 64-bit canonical fraction, with its payload packed against the most significant end. The destination fraction is then cut from the top of that word. Widening therefore keeps the payload and pads it with zeros. Narrowing keeps the high payload bits and drops the low ones.

Two fallbacks replace the result with the destination format's default NaN. The first applies when the payload that survives the cut is all zeros, since the result would otherwise read as an infinity. The second applies when the default-NaN control is high. A convention input sets the meaning of the top fraction bit and picks the matching default NaN patterns. A signaling source raises an invalid pulse alongside the result. That pulse is also ORed into a sticky flag, which keeps its value until a synchronous clear. The result is registered, so it appears one cycle after the input is presented.

Top module: `nan_fmt_conv`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises with nothing presented, `out_valid`, `out_invalid` and `invalid_sticky` are 0.
- R2: `out_valid` equals `in_valid` of the previous cycle. `out_val` and `out_invalid` take a new value only on a cycle after `in_valid` was high. After an idle cycle, `out_val` holds its old value and `out_invalid` is 0.
- R3: Format codes on `src_fmt`/`dst_fmt` are 0 half (1/5/10 sign/exponent/fraction bits), 1 single (1/8/23) and 2 double (1/11/52). The result is right-aligned in `out_val` with zeros above it. It has an all-ones exponent and the source sign. Its fraction is the top bits of the source fraction placed at the top of the 64-bit canonical word. Source bits above the source width are ignored.
- R4: If the destination fraction cut from the canonical word is zero, the result is the destination default NaN.
- R5: With `dflt_nan_en` high, the result is always the destination default NaN, whatever the sign and payload.
- R6: Default NaNs with `snan_conv`=0 are 0xFE00, 0xFFC00000 and 0xFFF8000000000000. With `snan_conv`=1 they are 0x7DFF, 0x7FBFFFFF and 0x7FF7FFFFFFFFFFFF.
- R7: With `snan_conv`=0, the source is signaling when its top fraction bit is 0 and some other fraction bit is 1. With `snan_conv`=1, it is signaling when its top fraction bit is 1. A signaling source sets `out_invalid` with its result, and this also holds in default-NaN mode.
- R8: The quiet bit is never forced. A signaling payload that survives the cut is passed through unchanged.
- R9: `invalid_sticky` rises on the edge that raises `out_invalid`. It then stays high until an edge with `flags_clr` high clears it. An invalid event on the same edge as a clear leaves it set.
- R10: Format code 3 behaves as double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| src_val | input | 64 | Source NaN, right-aligned |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| dflt_nan_en | input | 1 | Force the default NaN result |
| snan_conv | input | 1 | Quiet-bit convention select |
| flags_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid |
| out_val | output | 64 | Converted NaN, right-aligned |
| out_invalid | output | 1 | Source was signaling |
| invalid_sticky | output | 1 | Accumulated invalid flag |

## Verification
The bench drives narrowing cases whose payload lives only in the low bits. A design that failed to substitute the default NaN there would emit an infinity. Signaling sources are checked under both conventions and in default-NaN mode. A converter that forced the quiet bit would change the payload, and one that skipped the invalid check in default mode would lose the exception. A clear that arrives on the same cycle as a new invalid event is also driven. A design that let the clear win there would drop that event. Junk above the source width and format code 3 are included as well, to catch width-slicing and decode mistakes.

// File: rtl/nanfmt_pkg.sv
package nanfmt_pkg;

    localparam int CANON_W = 64;
    localparam int VAL_W   = 64;
    localparam int NUM_FMT = 3;

    function automatic int fmt_exp_w(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_frac_w(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    // code 3 folds onto the double lane
    function automatic logic [1:0] fmt_lane(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    typedef struct packed {
        logic             valid;
        logic [VAL_W-1:0] val;
        logic             invalid;
        logic             sticky;
    } conv_state_t;

endpackage

// File: rtl/nan_lane_unpack.sv
module nan_lane_unpack #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int CANON_W = 64,
    localparam int TOT_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [TOT_W-1:0]   value,
    input  logic               snan_conv,
    output logic               sign,
    output logic [CANON_W-1:0] canon_frac,
    output logic               is_snan
);
    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              top_bit;
    logic              rest_set;

    always_comb begin
        sign       = value[TOT_W-1];
        frac       = value[FRAC_W-1:0];
        exp_ones   = &value[FRAC_W +: EXP_W];
        top_bit    = frac[FRAC_W-1];
        rest_set   = |frac[FRAC_W-2:0];
        is_snan    = exp_ones & (snan_conv ? top_bit : (~top_bit & rest_set));
        canon_frac = CANON_W'(frac) << (CANON_W - FRAC_W);
    end
endmodule

// File: rtl/nan_lane_pack.sv
module nan_lane_pack #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    localparam int TOT_W  = 1 + EXP_W + FRAC_W
) (
    input  logic              sign,
    input  logic [FRAC_W-1:0] frac_top,
    input  logic              dflt_nan_en,
    input  logic              snan_conv,
    output logic [TOT_W-1:0]  value
);
    logic [TOT_W-1:0] dflt;

    always_comb begin
        if (snan_conv)
            dflt = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
        else
            dflt = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

        if (dflt_nan_en || (frac_top == '0))
            value = dflt;
        else
            value = {sign, {EXP_W{1'b1}}, frac_top};
    end
endmodule

// File: rtl/nan_fmt_conv.sv
module nan_fmt_conv
    import nanfmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] src_val,
    input  logic [1:0]  src_fmt,
    input  logic [1:0]  dst_fmt,
    input  logic        dflt_nan_en,
    input  logic        snan_conv,
    input  logic        flags_clr,
    output logic        out_valid,
    output logic [63:0] out_val,
    output logic        out_invalid,
    output logic        invalid_sticky
);
    logic               lane_sign [NUM_FMT];
    logic [CANON_W-1:0] lane_frac [NUM_FMT];
    logic               lane_snan [NUM_FMT];
    logic [VAL_W-1:0]   lane_out  [NUM_FMT];

    logic               canon_sign;
    logic [CANON_W-1:0] canon_frac;
    logic               src_snan;
    logic [1:0]         src_idx;
    logic [1:0]         dst_idx;
    logic               canon_unused;

    conv_state_t st_d, st_q;

    always_comb begin
        src_idx    = fmt_lane(src_fmt);
        dst_idx    = fmt_lane(dst_fmt);
        canon_sign = lane_sign[src_idx];
        canon_frac = lane_frac[src_idx];
        src_snan   = lane_snan[src_idx];
    end

    // the widest destination never reads the bottom of the canonical word
    assign canon_unused = ^canon_frac[CANON_W-fmt_frac_w(NUM_FMT-1)-1:0];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
        localparam int EW = fmt_exp_w(g);
        localparam int FW = fmt_frac_w(g);
        localparam int TW = 1 + EW + FW;
        logic [TW-1:0] packed_val;

        nan_lane_unpack #(
            .EXP_W   (EW),
            .FRAC_W  (FW),
            .CANON_W (CANON_W)
        ) u_unpack (
            .value      (src_val[TW-1:0]),
            .snan_conv  (snan_conv),
            .sign       (lane_sign[g]),
            .canon_frac (lane_frac[g]),
            .is_snan    (lane_snan[g])
        );

        nan_lane_pack #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_pack (
            .sign        (canon_sign),
            .frac_top    (canon_frac[CANON_W-1 -: FW]),
            .dflt_nan_en (dflt_nan_en),
            .snan_conv   (snan_conv),
            .value       (packed_val)
        );

        assign lane_out[g] = VAL_W'(packed_val);
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.invalid = in_valid & src_snan;
        if (in_valid)
            st_d.val = lane_out[dst_idx];
        st_d.sticky  = (st_q.sticky & ~flags_clr) | (in_valid & src_snan);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid      = st_q.valid;
    assign out_val        = st_q.val;
    assign out_invalid    = st_q.invalid;
    assign invalid_sticky = st_q.sticky;

endmodule

// File: rtl/nan_fmt_conv_checker.sv
module nan_fmt_conv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  dst_fmt,
    input logic        dflt_nan_en,
    input logic        snan_conv,
    input logic        flags_clr,
    input logic        out_valid,
    input logic [63:0] out_val,
    input logic        out_invalid,
    input logic        invalid_sticky
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid |=> out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !in_valid |=> !out_valid && !out_invalid && $stable(out_val));

    assert_single_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid && dst_fmt == 2'd1 |=>
            out_val[63:32] == 32'h0 && out_val[30:23] == 8'hFF);

    assert_default_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid && dflt_nan_en && dst_fmt == 2'd1 && !snan_conv |=>
            out_val == 64'h00000000FFC00000);

    assert_invalid_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_valid);

    assert_invalid_sets_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> invalid_sticky);

    assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && invalid_sticky && !flags_clr |=> invalid_sticky);

    assert_sticky_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(invalid_sticky) |-> out_invalid);
endmodule

bind nan_fmt_conv nan_fmt_conv_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .dst_fmt        (dst_fmt),
    .dflt_nan_en    (dflt_nan_en),
    .snan_conv      (snan_conv),
    .flags_clr      (flags_clr),
    .out_valid      (out_valid),
    .out_val        (out_val),
    .out_invalid    (out_invalid),
    .invalid_sticky (invalid_sticky)
);

// File: tb/nan_fmt_conv_tb.sv
module nan_fmt_conv_tb;

    typedef struct packed {
        logic [1:0]  sf;
        logic [1:0]  df;
        logic        dm;
        logic        cv;
        logic [63:0] src;
        logic [63:0] exp_val;
        logic        exp_inv;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 2'd2, 1'b0, 1'b0, 64'h000000007FC00001, 64'h7FF8000020000000, 1'b0}, // R3 widen
        '{2'd1, 2'd2, 1'b0, 1'b0, 64'h00000000FF800005, 64'hFFF00000A0000000, 1'b1}, // R8 R7
        '{2'd2, 2'd1, 1'b0, 1'b0, 64'h7FF8000000000001, 64'h000000007FC00000, 1'b0}, // R3 narrow
        '{2'd2, 2'd1, 1'b0, 1'b0, 64'h7FF0000000000001, 64'h00000000FFC00000, 1'b1}, // R4
        '{2'd2, 2'd0, 1'b0, 1'b0, 64'hFFF4000000000000, 64'h000000000000FD00, 1'b1}, // R3 R8
        '{2'd0, 2'd1, 1'b0, 1'b0, 64'h0000000000007E01, 64'h000000007FC02000, 1'b0}, // R3
        '{2'd0, 2'd2, 1'b0, 1'b0, 64'h000000000000FC01, 64'hFFF0040000000000, 1'b1}, // R3 R7
        '{2'd1, 2'd0, 1'b0, 1'b0, 64'h000000007F800100, 64'h000000000000FE00, 1'b1}, // R4 R6
        '{2'd1, 2'd2, 1'b1, 1'b0, 64'h000000007FC12345, 64'hFFF8000000000000, 1'b0}, // R5
        '{2'd1, 2'd1, 1'b1, 1'b0, 64'h000000007F800001, 64'h00000000FFC00000, 1'b1}, // R5 R7
        '{2'd1, 2'd1, 1'b0, 1'b1, 64'h000000007FC00001, 64'h000000007FC00001, 1'b1}, // R7 conv1
        '{2'd1, 2'd1, 1'b0, 1'b1, 64'h000000007F800001, 64'h000000007F800001, 1'b0}, // R7 conv1
        '{2'd2, 2'd0, 1'b0, 1'b1, 64'h7FF0000000000001, 64'h0000000000007DFF, 1'b0}, // R4 R6
        '{2'd0, 2'd2, 1'b1, 1'b1, 64'h0000000000007C01, 64'h7FF7FFFFFFFFFFFF, 1'b0}, // R6
        '{2'd1, 2'd1, 1'b1, 1'b1, 64'h00000000FFC00000, 64'h000000007FBFFFFF, 1'b1}, // R6
        '{2'd3, 2'd1, 1'b0, 1'b0, 64'h7FF8000000000000, 64'h000000007FC00000, 1'b0}, // R10
        '{2'd1, 2'd1, 1'b0, 1'b0, 64'hDEADBEEF7FC00003, 64'h000000007FC00003, 1'b0}  // R3 junk
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] src_val;
    logic [1:0]  src_fmt;
    logic [1:0]  dst_fmt;
    logic        dflt_nan_en;
    logic        snan_conv;
    logic        flags_clr;
    logic        out_valid;
    logic [63:0] out_val;
    logic        out_invalid;
    logic        invalid_sticky;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    nan_fmt_conv u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .src_val        (src_val),
        .src_fmt        (src_fmt),
        .dst_fmt        (dst_fmt),
        .dflt_nan_en    (dflt_nan_en),
        .snan_conv      (snan_conv),
        .flags_clr      (flags_clr),
        .out_valid      (out_valid),
        .out_val        (out_val),
        .out_invalid    (out_invalid),
        .invalid_sticky (invalid_sticky)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic        exp_sticky;
        logic [63:0] last_val;
        rst_n = 1'b0; in_valid = 1'b0; src_val = '0; src_fmt = '0; dst_fmt = '0;
        dflt_nan_en = 1'b0; snan_conv = 1'b0; flags_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid",  64'(out_valid), 64'd0);
        check("R1 inv",    64'(out_invalid), 64'd0);
        check("R1 sticky", 64'(invalid_sticky), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 idle after reset", 64'(out_valid), 64'd0);

        exp_sticky = 1'b0;
        last_val   = '0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1; src_fmt = VEC[i].sf; dst_fmt = VEC[i].df;
            dflt_nan_en = VEC[i].dm; snan_conv = VEC[i].cv; src_val = VEC[i].src;
            @(posedge clk); #1;
            exp_sticky = exp_sticky | VEC[i].exp_inv;
            last_val   = VEC[i].exp_val;
            check($sformatf("R3-R10 vec%0d value", i), out_val, VEC[i].exp_val);
            check($sformatf("R7 vec%0d invalid", i), 64'(out_invalid), 64'(VEC[i].exp_inv));
            check($sformatf("R2 vec%0d valid", i), 64'(out_valid), 64'd1);
            check($sformatf("R9 vec%0d sticky", i), 64'(invalid_sticky), 64'(exp_sticky));
        end

        // R2: idle cycle with a signaling operand on the bus
        @(negedge clk);
        in_valid = 1'b0; src_fmt = 2'd1; dst_fmt = 2'd1; dflt_nan_en = 1'b0;
        snan_conv = 1'b0; src_val = 64'h000000007F800001;
        @(posedge clk); #1;
        check("R2 idle valid", 64'(out_valid), 64'd0);
        check("R2 idle inv",   64'(out_invalid), 64'd0);
        check("R2 idle hold",  out_val, last_val);
        check("R9 sticky holds", 64'(invalid_sticky), 64'd1);

        // R9: clear alone
        @(negedge clk); flags_clr = 1'b1;
        @(posedge clk); #1;
        check("R9 clear", 64'(invalid_sticky), 64'd0);

        // R9: quiet conversion leaves flag clear
        @(negedge clk); flags_clr = 1'b0; in_valid = 1'b1; src_val = 64'h000000007FC00000;
        @(posedge clk); #1;
        check("R9 quiet no set", 64'(invalid_sticky), 64'd0);

        // R9: invalid event coincident with clear
        @(negedge clk); flags_clr = 1'b1; src_val = 64'h000000007F800001;
        @(posedge clk); #1;
        check("R9 event beats clear", 64'(invalid_sticky), 64'd1);
        check("R7 coincident inv", 64'(out_invalid), 64'd1);

        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        check("R9 clear after", 64'(invalid_sticky), 64'd0);
        flags_clr = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule